// File: doc/BRIEF.md
# Three-Phase 16-bit Eight-Operation Processor Core

This block is a small processor core with eight 16-bit general registers. It executes a fixed 16-bit instruction word that carries a 3-bit operation field. Every instruction passes through three controller phases, one clock each: FETCH, DECODE and EXECUTE. In FETCH the word at the program counter is latched into the instruction register. In DECODE the three register fields index the register file, and its read data is registered. In EXECUTE a purely combinational ALU forms the result. At the end of EXECUTE the core commits the register write, the memory store and the next program counter together.

Instruction memory is read through an address and data pair with combinational return. Data memory has a combinational read, and a write strobe that is sampled on the rising clock edge. Both memories can be plain arrays outside the core. Reset is synchronous and active high.

Phases and transitions: FETCH goes to DECODE, DECODE goes to EXECUTE, and EXECUTE goes to FETCH, unconditionally. Reset forces FETCH from any phase.

Top module: `mc16_core`

## Requirements
- R1: Instruction fields: operation in bits 15:13, register A in 12:10, register B in 9:7, register C in 2:0, a 7-bit immediate in 6:0 and a 10-bit immediate in 9:0. Operation codes: 000 add, 001 add-immediate, 010 nand, 011 load-upper, 100 store, 101 load, 110 branch-if-equal, 111 jump-and-link.
- R2: Each instruction takes exactly three clocks (FETCH, DECODE, EXECUTE). The program counter, and therefore `imem_addr`, changes only on the edge that ends EXECUTE. Register read data is captured at the end of DECODE.
- R3: While `rst` is high at a rising edge, the core returns to FETCH, clears the program counter and all registers, and holds `dmem_we` low.
- R4: Register 0 always reads as zero. A write to it is discarded.
- R5: Add writes B+C into A (modulo 2^16). Nand writes ~(B & C) into A.
- R6: Add-immediate writes B plus the sign-extended 7-bit immediate (range -64..63) into A.
- R7: Load-upper writes the 10-bit immediate into A[15:6] and clears A[5:0].
- R8: Load and store address data memory at B plus the sign-extended 7-bit immediate. Store writes register A with a single-cycle `dmem_we` pulse during EXECUTE. Load writes the memory word into A.
- R9: Branch-if-equal sets PC to PC+1+sext(imm7) when A equals B, and to PC+1 otherwise. Backward offsets are allowed.
- R10: Jump-and-link writes PC+1 into A and sets PC to the value B held before the instruction.
- R11: Every operation other than a taken branch or a jump-and-link advances PC by one word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 16 | Word address of the instruction memory (the program counter) |
| imem_rdata | input | 16 | Instruction word at `imem_addr` |
| dmem_addr | output | 16 | Word address of the data memory |
| dmem_wdata | output | 16 | Store data (register A) |
| dmem_we | output | 1 | Store strobe, one cycle in EXECUTE of a store |
| dmem_rdata | input | 16 | Data word at `dmem_addr` |

## Verification
A phase controller that slips or sticks shows up within three clocks: `imem_addr` moves at the wrong edge, or stops moving. A wrong register value, a wrong sign extension or a bad branch decision stays hidden inside the core. It becomes visible only when a later store puts the value on `dmem_wdata`, or when the program counter takes a wrong path. For that reason every computed value in the test program is stored to its own data address and compared after the program reaches its halt loop. Skipped stores leave sentinel words that expose taken branches, and a count of `dmem_we` pulses exposes stray or lost stores.

// File: rtl/mc16_pkg.sv
package mc16_pkg;

    localparam int INSN_W = 16;
    localparam int IDX_W  = 3;
    localparam int SIMM_W = 7;
    localparam int UIMM_W = 10;

    typedef enum logic [2:0] {
        OP_ADD  = 3'b000,
        OP_ADDI = 3'b001,
        OP_NAND = 3'b010,
        OP_LUI  = 3'b011,
        OP_SW   = 3'b100,
        OP_LW   = 3'b101,
        OP_BEQ  = 3'b110,
        OP_JALR = 3'b111
    } opcode_e;

    typedef enum logic [1:0] {
        PH_FETCH  = 2'd0,
        PH_DECODE = 2'd1,
        PH_EXEC   = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        PC_STEP   = 2'd0,
        PC_BRANCH = 2'd1,
        PC_JUMP   = 2'd2
    } pcsel_e;

    typedef struct packed {
        opcode_e              op;
        logic [IDX_W-1:0]     ra;
        logic [IDX_W-1:0]     rb;
        logic [IDX_W-1:0]     rc;
        logic [SIMM_W-1:0]    simm;
        logic [UIMM_W-1:0]    uimm;
    } fields_t;

    function automatic fields_t split_word(input logic [INSN_W-1:0] w);
        fields_t f;
        f.op   = opcode_e'(w[15:13]);
        f.ra   = w[12:10];
        f.rb   = w[9:7];
        f.rc   = w[2:0];
        f.simm = w[6:0];
        f.uimm = w[9:0];
        return f;
    endfunction

    function automatic logic writes_reg(input opcode_e op);
        return (op == OP_ADD) || (op == OP_ADDI) || (op == OP_NAND) ||
               (op == OP_LUI) || (op == OP_LW) || (op == OP_JALR);
    endfunction

endpackage

// File: rtl/mc16_regfile.sv
module mc16_regfile
    import mc16_pkg::*;
#(
    parameter int W    = 16,
    parameter int NREG = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    rd_en,
    input  logic [$clog2(NREG)-1:0] ra_idx,
    input  logic [$clog2(NREG)-1:0] rb_idx,
    input  logic [$clog2(NREG)-1:0] rc_idx,
    output logic [W-1:0]            ra_q,
    output logic [W-1:0]            rb_q,
    output logic [W-1:0]            rc_q,
    input  logic                    wr_en,
    input  logic [$clog2(NREG)-1:0] wr_idx,
    input  logic [W-1:0]            wr_data
);
    localparam int AW = $clog2(NREG);

    logic [W-1:0] regs [NREG];

    // Entry 0 is never written, so it stays at its reset value of zero.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (wr_en) begin
            for (int i = 1; i < NREG; i++) begin
                if (wr_idx == AW'(i)) regs[i] <= wr_data;
            end
        end
    end

    // Reads have one clock of latency: data is captured while rd_en is high.
    always_ff @(posedge clk) begin
        if (rst) begin
            ra_q <= '0;
            rb_q <= '0;
            rc_q <= '0;
        end else if (rd_en) begin
            ra_q <= (ra_idx == '0) ? '0 : regs[ra_idx];
            rb_q <= (rb_idx == '0) ? '0 : regs[rb_idx];
            rc_q <= (rc_idx == '0) ? '0 : regs[rc_idx];
        end
    end

    // R4: a read of index 0 yields zero one cycle later, whatever was written.
    a_r4_zero_reg_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && rb_idx == '0) |=> (rb_q == '0));

    // R2: read data holds outside the capture cycle.
    a_r2_read_data_held: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> $stable(ra_q) && $stable(rb_q) && $stable(rc_q));

endmodule

// File: rtl/mc16_alu.sv
module mc16_alu
    import mc16_pkg::*;
#(
    parameter int W = 16
) (
    input  opcode_e        op,
    input  logic [W-1:0]   opnd_a,
    input  logic [W-1:0]   opnd_b,
    input  logic [W-1:0]   opnd_c,
    input  logic [W-1:0]   simm_x,
    input  logic [W-1:0]   upper_val,
    input  logic [W-1:0]   pc_plus1,
    output logic [W-1:0]   result,
    output logic [W-1:0]   eff_addr,
    output logic           equal
);
    assign eff_addr = opnd_b + simm_x;
    assign equal    = (opnd_a == opnd_b);

    always_comb begin
        unique case (op)
            OP_ADD:  result = opnd_b + opnd_c;
            OP_ADDI: result = eff_addr;
            OP_NAND: result = ~(opnd_b & opnd_c);
            OP_LUI:  result = upper_val;
            OP_JALR: result = pc_plus1;
            default: result = '0;
        endcase
    end

endmodule

// File: rtl/mc16_seq.sv
module mc16_seq
    import mc16_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  opcode_e op,
    input  logic    equal,
    output phase_e  phase,
    output logic    ir_load,
    output logic    rf_rd_en,
    output logic    rf_we,
    output logic    mem_we,
    output logic    pc_load,
    output pcsel_e  pc_sel
);
    phase_e phase_q, phase_d;

    always_ff @(posedge clk) begin
        if (rst) phase_q <= PH_FETCH;
        else     phase_q <= phase_d;
    end

    always_comb begin
        unique case (phase_q)
            PH_FETCH:  phase_d = PH_DECODE;
            PH_DECODE: phase_d = PH_EXEC;
            PH_EXEC:   phase_d = PH_FETCH;
            default:   phase_d = PH_FETCH;
        endcase
    end

    always_comb begin
        ir_load  = 1'b0;
        rf_rd_en = 1'b0;
        rf_we    = 1'b0;
        mem_we   = 1'b0;
        pc_load  = 1'b0;
        pc_sel   = PC_STEP;
        unique case (phase_q)
            PH_FETCH:  ir_load  = 1'b1;
            PH_DECODE: rf_rd_en = 1'b1;
            PH_EXEC: begin
                rf_we   = writes_reg(op);
                mem_we  = (op == OP_SW);
                pc_load = 1'b1;
                if (op == OP_JALR)              pc_sel = PC_JUMP;
                else if (op == OP_BEQ && equal) pc_sel = PC_BRANCH;
                else                            pc_sel = PC_STEP;
            end
            default: ;
        endcase
    end

    assign phase = phase_q;

    // R2: the fixed three-phase ring.
    a_r2_fetch_to_decode: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FETCH) |=> (phase_q == PH_DECODE));
    a_r2_decode_to_exec: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_DECODE) |=> (phase_q == PH_EXEC));
    a_r2_exec_to_fetch: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_EXEC) |=> (phase_q == PH_FETCH));

endmodule

// File: rtl/mc16_core.sv
module mc16_core
    import mc16_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst,
    output logic [DATA_W-1:0] imem_addr,
    input  logic [15:0]       imem_rdata,
    output logic [DATA_W-1:0] dmem_addr,
    output logic [DATA_W-1:0] dmem_wdata,
    output logic              dmem_we,
    input  logic [DATA_W-1:0] dmem_rdata
);
    localparam int AW     = $clog2(NREG);
    localparam int LOW_W  = DATA_W - UIMM_W;

    logic [DATA_W-1:0] pc_q;
    logic [15:0]       ir_q;
    fields_t           fld;

    phase_e  phase;
    logic    ir_load, rf_rd_en, rf_we, pc_load;
    pcsel_e  pc_sel;

    logic [DATA_W-1:0] rd_a, rd_b, rd_c;
    logic [DATA_W-1:0] simm_x, upper_val, pc_plus1, br_target;
    logic [DATA_W-1:0] alu_res, eff_addr, wb_data, pc_next;
    logic              equal;

    assign fld       = split_word(ir_q);
    assign simm_x    = {{(DATA_W-SIMM_W){fld.simm[SIMM_W-1]}}, fld.simm};
    assign upper_val = {fld.uimm, {LOW_W{1'b0}}};
    assign pc_plus1  = pc_q + DATA_W'(1);
    assign br_target = pc_plus1 + simm_x;

    always_ff @(posedge clk) begin
        if (rst)          ir_q <= '0;
        else if (ir_load) ir_q <= imem_rdata;
    end

    always_comb begin
        unique case (pc_sel)
            PC_BRANCH: pc_next = br_target;
            PC_JUMP:   pc_next = rd_b;
            default:   pc_next = pc_plus1;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)          pc_q <= '0;
        else if (pc_load) pc_q <= pc_next;
    end

    mc16_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .op       (fld.op),
        .equal    (equal),
        .phase    (phase),
        .ir_load  (ir_load),
        .rf_rd_en (rf_rd_en),
        .rf_we    (rf_we),
        .mem_we   (dmem_we),
        .pc_load  (pc_load),
        .pc_sel   (pc_sel)
    );

    mc16_regfile #(.W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst     (rst),
        .rd_en   (rf_rd_en),
        .ra_idx  (AW'(fld.ra)),
        .rb_idx  (AW'(fld.rb)),
        .rc_idx  (AW'(fld.rc)),
        .ra_q    (rd_a),
        .rb_q    (rd_b),
        .rc_q    (rd_c),
        .wr_en   (rf_we),
        .wr_idx  (AW'(fld.ra)),
        .wr_data (wb_data)
    );

    mc16_alu #(.W(DATA_W)) u_alu (
        .op        (fld.op),
        .opnd_a    (rd_a),
        .opnd_b    (rd_b),
        .opnd_c    (rd_c),
        .simm_x    (simm_x),
        .upper_val (upper_val),
        .pc_plus1  (pc_plus1),
        .result    (alu_res),
        .eff_addr  (eff_addr),
        .equal     (equal)
    );

    assign wb_data    = (fld.op == OP_LW) ? dmem_rdata : alu_res;
    assign imem_addr  = pc_q;
    assign dmem_addr  = eff_addr;
    assign dmem_wdata = rd_a;

    // R2: the program counter moves only on the edge that ends EXECUTE.
    a_r2_pc_held_outside_exec: assert property (@(posedge clk) disable iff (rst)
        (phase != PH_EXEC) |=> $stable(pc_q));

    // R8: a store strobe lasts one cycle and belongs to a store in EXECUTE.
    a_r8_store_single_cycle: assert property (@(posedge clk) disable iff (rst)
        dmem_we |=> !dmem_we);
    a_r8_store_in_exec: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> (phase == PH_EXEC && fld.op == OP_SW));

    // R9: an untaken branch steps by one word.
    a_r9_untaken_steps: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_EXEC && fld.op == OP_BEQ && !equal) |=> (pc_q == $past(pc_q) + DATA_W'(1)));

endmodule

// File: tb/mc16_core_bench.sv
`timescale 1ns/1ps
module mc16_core_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] imem_addr, imem_rdata;
    logic [15:0] dmem_addr, dmem_wdata, dmem_rdata;
    logic        dmem_we;

    logic [15:0] imem [64];
    logic [15:0] dmem [64];

    int checks = 0;
    int errors = 0;
    int stores = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    mc16_core u_mc16_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we),
        .dmem_rdata (dmem_rdata)
    );

    assign imem_rdata = imem[imem_addr[5:0]];
    assign dmem_rdata = dmem[dmem_addr[5:0]];

    always @(posedge clk) begin
        if (!rst && dmem_we) begin
            dmem[dmem_addr[5:0]] <= dmem_wdata;
            stores <= stores + 1;
        end
    end

    // R1 field layout used by the encoders below.
    function automatic logic [15:0] enc_r(input logic [2:0] op, a, b, c);
        return {op, a, b, 4'b0000, c};
    endfunction
    function automatic logic [15:0] enc_i(input logic [2:0] op, a, b, input int imm);
        logic [31:0] t = imm;
        return {op, a, b, t[6:0]};
    endfunction
    function automatic logic [15:0] enc_u(input logic [2:0] op, a, input logic [9:0] imm);
        return {op, a, imm};
    endfunction

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // {requirement[3:0], data address[5:0], expected word[15:0]}
    localparam int NEXP = 13;
    localparam logic [25:0] EXPECT [NEXP] = '{
        {4'd6,  6'd32, 16'h0005},  // R6 positive immediate
        {4'd6,  6'd33, 16'hFFFD},  // R6 negative immediate
        {4'd1,  6'd34, 16'h0002},  // R1 three-register format, add
        {4'd5,  6'd35, 16'hFFFA},  // R5 nand
        {4'd7,  6'd36, 16'hFFFF},  // R7 upper load plus +63
        {4'd6,  6'd37, 16'hFFC0},  // R6 minimum immediate -64
        {4'd4,  6'd38, 16'h0000},  // R4 register 0 write discarded
        {4'd8,  6'd39, 16'h0005},  // R8 load, then store at base+offset
        {4'd9,  6'd40, 16'h1111},  // R9 taken branch skipped store
        {4'd11, 6'd41, 16'h0002},  // R11 untaken branch falls through
        {4'd10, 6'd42, 16'h2222},  // R10 jump skipped store
        {4'd10, 6'd43, 16'h0017},  // R10 link value 23
        {4'd9,  6'd44, 16'h0003}   // R9 backward branch loop count
    };

    initial begin
        for (int i = 0; i < 64; i++) begin
            imem[i] = 16'h0000;
            dmem[i] = 16'h0000;
        end
        dmem[38] = 16'hAAAA;
        dmem[40] = 16'h1111;
        dmem[42] = 16'h2222;
        imem[0]  = enc_i(3'b001, 3'd1, 3'd0, 5);
        imem[1]  = enc_i(3'b001, 3'd2, 3'd0, -3);
        imem[2]  = enc_r(3'b000, 3'd3, 3'd1, 3'd2);
        imem[3]  = enc_r(3'b010, 3'd4, 3'd1, 3'd2);
        imem[4]  = enc_u(3'b011, 3'd5, 10'h3FF);
        imem[5]  = enc_i(3'b001, 3'd5, 3'd5, 63);
        imem[6]  = enc_i(3'b001, 3'd6, 3'd0, -64);
        imem[7]  = enc_i(3'b001, 3'd0, 3'd0, 7);
        imem[8]  = enc_i(3'b100, 3'd1, 3'd0, 32);
        imem[9]  = enc_i(3'b100, 3'd2, 3'd0, 33);
        imem[10] = enc_i(3'b100, 3'd3, 3'd0, 34);
        imem[11] = enc_i(3'b100, 3'd4, 3'd0, 35);
        imem[12] = enc_i(3'b100, 3'd5, 3'd0, 36);
        imem[13] = enc_i(3'b100, 3'd6, 3'd0, 37);
        imem[14] = enc_i(3'b100, 3'd0, 3'd0, 38);
        imem[15] = enc_i(3'b101, 3'd7, 3'd0, 32);
        imem[16] = enc_i(3'b100, 3'd7, 3'd3, 37);
        imem[17] = enc_i(3'b110, 3'd1, 3'd7, 1);
        imem[18] = enc_i(3'b100, 3'd2, 3'd0, 40);
        imem[19] = enc_i(3'b110, 3'd1, 3'd2, 1);
        imem[20] = enc_i(3'b100, 3'd3, 3'd0, 41);
        imem[21] = enc_i(3'b001, 3'd1, 3'd0, 25);
        imem[22] = enc_i(3'b111, 3'd2, 3'd1, 0);
        imem[23] = enc_i(3'b100, 3'd3, 3'd0, 42);
        imem[24] = enc_i(3'b001, 3'd0, 3'd0, 0);
        imem[25] = enc_i(3'b100, 3'd2, 3'd0, 43);
        imem[26] = enc_i(3'b001, 3'd4, 3'd0, 0);
        imem[27] = enc_i(3'b001, 3'd5, 3'd0, 3);
        imem[28] = enc_i(3'b001, 3'd4, 3'd4, 1);
        imem[29] = enc_i(3'b110, 3'd4, 3'd5, 1);
        imem[30] = enc_i(3'b110, 3'd0, 3'd0, -3);
        imem[31] = enc_i(3'b100, 3'd4, 3'd0, 44);
        imem[32] = enc_i(3'b110, 3'd0, 3'd0, -1);
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R3", "pc in reset", imem_addr, 16'h0000);
        check("R3", "store strobe in reset", {15'b0, dmem_we}, 16'h0000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", "pc before exec edge", imem_addr, 16'h0000);
        @(negedge clk);
        check("R2", "pc after three clocks", imem_addr, 16'h0001);

        repeat (300) @(negedge clk);
        for (int i = 0; i < NEXP; i++) begin
            check($sformatf("R%0d", EXPECT[i][25:22]),
                  $sformatf("dmem[%0d]", EXPECT[i][21:16]),
                  dmem[EXPECT[i][21:16]], EXPECT[i][15:0]);
        end
        check("R8", "store pulse count", 16'(stores), 16'd11);
        check("R9", "halt loop pc", imem_addr, 16'd32);

        // Reset in the middle of execution.
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R3", "pc after mid-run reset", imem_addr, 16'h0000);
        check("R3", "no store during reset", {15'b0, dmem_we}, 16'h0000);
        rst = 1'b0;
        repeat (2) @(negedge clk);
        check("R2", "restart pc held", imem_addr, 16'h0000);
        @(negedge clk);
        check("R2", "restart pc steps", imem_addr, 16'h0001);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule